// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for burst accesses to a synchronous SRAM core. A command strobe with the load flag set captures a start address and a read or write direction. Each later command with the load flag clear is an advance, and it moves to the next address of a four-beat burst. The burst order is linear counting or XOR interleave, as chosen by an order input.

The low address bits act as the burst counter and the upper bits stay fixed for the whole burst. The direction and the order are captured at load time. Every advanced address carries that direction, so one burst holds only reads or only writes. The outputs are the current address, its direction and a one-cycle valid flag, and they go straight to a memory core. A new load at any time drops the burst in progress.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `valid_out` is 0, `addr_out` is 0 and `wr_out` is 0.
- R2: In the cycle after an accepted load (`cmd_valid`=1, `cmd_load`=1), `valid_out` is 1, `addr_out` equals the sampled `start_addr`, and `wr_out` equals the sampled `cmd_write`.
- R3: When the order captured at load is linear (`order_sel`=0), each advance (`cmd_valid`=1, `cmd_load`=0) sets the two least significant bits of `addr_out` to the start bits plus the beat index, modulo 4.
- R4: When the order captured at load is interleave (`order_sel`=1), beat k (k = 0..3) sets the two least significant bits of `addr_out` to the start bits XOR k.
- R5: Address bits above bit 1 keep the loaded value on every advance.
- R6: An advance keeps the direction captured at load and ignores `cmd_write`.
- R7: The advance that follows the fourth beat goes back to the first address of the sequence, and the pattern then repeats.
- R8: A load during a burst drops it. The next cycle shows the new start address and the new direction at beat 0.
- R9: An advance with no load since reset leaves `valid_out` at 0.
- R10: In a cycle with `cmd_valid`=0, `valid_out` is 0 in the next cycle and the burst position does not change.
- R11: `order_sel` is sampled only at load time. A change during a burst does not affect the order of that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_load | input | 1 | 1 = load a start address, 0 = advance |
| cmd_write | input | 1 | Direction for a load: 1 = write, 0 = read |
| order_sel | input | 1 | Burst order for a load: 0 = linear, 1 = interleave |
| start_addr | input | ADDR_W | Start address for a load |
| addr_out | output | ADDR_W | Current burst address |
| wr_out | output | 1 | Direction of the current address |
| valid_out | output | 1 | Address and direction are issued this cycle |

## Verification
The assertions assume that `cmd_load`, `cmd_write`, `order_sel` and `start_addr` carry known values in every cycle with `cmd_valid` high, and that reset is held for at least one clock edge. The bench drives every input on the falling edge and never leaves one undefined. During reset and idle cycles it also holds the inputs at defined values. Between the directed segments it runs a random mix of loads, advances and idle cycles that goes through both orders and both directions. It also toggles `cmd_write` and `order_sel` inside bursts.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } bseq_order_e;
endpackage

// File: rtl/bseq_order.sv
`timescale 1ns/1ps
// Maps base bits and a beat index to the low address bits.
module bseq_order #(
   parameter int CNT_W = 2
) (
   input  logic [CNT_W-1:0]        base,
   input  logic [CNT_W-1:0]        beat,
   input  bseq_pkg::bseq_order_e   order,
   output logic [CNT_W-1:0]        low
);
   logic [CNT_W-1:0] lin_bits;
   logic [CNT_W-1:0] xor_bits;

   assign lin_bits = base + beat;   // wraps modulo burst length

   for (genvar gi = 0; gi < CNT_W; gi++) begin : g_xor
      assign xor_bits[gi] = base[gi] ^ beat[gi];
   end

   assign low = (order == bseq_pkg::ORD_INTERLEAVE) ? xor_bits : lin_bits;
endmodule

// File: rtl/bseq_ctrl.sv
`timescale 1ns/1ps
// Burst state: armed flag, captured direction/order/start, beat index.
module bseq_ctrl #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   input  logic                     cmd_load,
   input  logic                     cmd_write,
   input  bseq_pkg::bseq_order_e    order_in,
   input  logic [ADDR_W-1:0]        start_addr,
   output logic                     armed_q,
   output logic                     dir_q,
   output bseq_pkg::bseq_order_e    order_q,
   output logic [CNT_W-1:0]         base_q,
   output logic [CNT_W-1:0]         beat_q,
   output logic [ADDR_W-CNT_W-1:0]  upper_q,
   output logic                     valid_q
);
   logic do_load;
   logic do_adv;

   assign do_load = cmd_valid &  cmd_load;
   assign do_adv  = cmd_valid & ~cmd_load & armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         dir_q   <= 1'b0;
         order_q <= bseq_pkg::ORD_LINEAR;
         base_q  <= '0;
         beat_q  <= '0;
         upper_q <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= do_load | do_adv;
         if (do_load) begin
            armed_q <= 1'b1;
            dir_q   <= cmd_write;
            order_q <= order_in;
            base_q  <= start_addr[CNT_W-1:0];
            upper_q <= start_addr[ADDR_W-1:CNT_W];
            beat_q  <= '0;
         end else if (do_adv) begin
            beat_q  <= beat_q + 1'b1;
         end
      end
   end

   AST_NO_VALID_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_load && !armed_q) |=> !valid_q);              // R9

   AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (do_adv && beat_q == {CNT_W{1'b1}}) |=> (beat_q == '0));         // R7

   AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_load) |=> (order_q == $past(order_q)));       // R11
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq #(
   parameter int ADDR_W    = 16,
   parameter int BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_load,
   input  logic              cmd_write,
   input  logic              order_sel,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] addr_out,
   output logic              wr_out,
   output logic              valid_out
);
   localparam int CNT_W = $clog2(BURST_LEN);

   initial begin
      assert (BURST_LEN >= 2 && (1 << CNT_W) == BURST_LEN)
         else $error("BURST_LEN must be a power of two, at least 2");
      assert (ADDR_W > CNT_W)
         else $error("ADDR_W must exceed the burst counter width");
   end

   logic                     armed;
   logic                     dir;
   bseq_pkg::bseq_order_e    order_q;
   bseq_pkg::bseq_order_e    order_in;
   logic [CNT_W-1:0]         base;
   logic [CNT_W-1:0]         beat;
   logic [ADDR_W-CNT_W-1:0]  upper;
   logic [CNT_W-1:0]         low;

   assign order_in = order_sel ? bseq_pkg::ORD_INTERLEAVE : bseq_pkg::ORD_LINEAR;

   bseq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_load   (cmd_load),
      .cmd_write  (cmd_write),
      .order_in   (order_in),
      .start_addr (start_addr),
      .armed_q    (armed),
      .dir_q      (dir),
      .order_q    (order_q),
      .base_q     (base),
      .beat_q     (beat),
      .upper_q    (upper),
      .valid_q    (valid_out)
   );

   bseq_order #(.CNT_W(CNT_W)) u_order (
      .base  (base),
      .beat  (beat),
      .order (order_q),
      .low   (low)
   );

   assign addr_out = {upper, low};
   assign wr_out   = dir;

   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_load) |=> (valid_out && addr_out == $past(start_addr)
                                   && wr_out == $past(cmd_write)));        // R2

   AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_load && armed)
         |=> (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]))); // R5

   AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_load && armed) |=> (wr_out == $past(wr_out)));     // R6

   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_load && armed && order_q == bseq_pkg::ORD_LINEAR)
         |=> (addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + 1'b1))); // R3

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> (!valid_out && $stable(addr_out) && $stable(wr_out)));  // R10
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_load = 1'b0;
   logic          cmd_write = 1'b0;
   logic          order_sel = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [AW-1:0] addr_out;
   logic          wr_out;
   logic          valid_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // behavioural reference state
   int    m_armed = 0, m_dir = 0, m_il = 0, m_base = 0, m_up = 0, m_k = 0, m_valid = 0;
   string cur_tag = "R1";

   always #5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_load(cmd_load),
      .cmd_write(cmd_write), .order_sel(order_sel), .start_addr(start_addr),
      .addr_out(addr_out), .wr_out(wr_out), .valid_out(valid_out));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      int low;
      low = m_il ? (m_base ^ m_k) : ((m_base + m_k) % 4);
      chk(cur_tag, "valid_out", int'(valid_out), m_valid);
      chk(cur_tag, "addr_out",  int'(addr_out), m_up * 4 + low);
      chk(cur_tag, "wr_out",    int'(wr_out), m_dir);
   endtask

   // compare previous cycle's result, then drive and advance the model
   task automatic step(input bit v, input bit ld, input bit wr, input int a,
                       input bit il, input string tag);
      @(negedge clk);
      compare();
      cmd_valid = v; cmd_load = ld; cmd_write = wr; order_sel = il;
      start_addr = AW'(a);
      cur_tag = tag;
      if (v && ld) begin
         m_armed = 1; m_dir = wr; m_il = il; m_base = a % 4; m_up = a / 4;
         m_k = 0; m_valid = 1;
      end else if (v && m_armed != 0) begin
         m_k = (m_k + 1) % 4; m_valid = 1;
      end else begin
         m_valid = 0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare();                          // R1 reset state
      rst_n = 1'b1;
      // R9: advances before any load
      step(1, 0, 1, 16'h1234, 0, "R9");
      step(1, 0, 0, 16'h0000, 1, "R9");
      // R2, R3, R5, R6, R7: linear write burst, start low bits 2
      step(1, 1, 1, 16'hABCE, 0, "R2");
      for (int i = 0; i < 6; i++) step(1, 0, i % 2, 16'h5555, 0, "R3");
      step(1, 0, 0, 16'h0000, 0, "R7");
      step(1, 0, 0, 16'hFFFF, 1, "R6");
      // R10: idle keeps position
      step(0, 1, 0, 16'h0F0F, 1, "R10");
      step(0, 0, 1, 16'h0000, 0, "R10");
      step(1, 0, 1, 16'h0000, 0, "R5");
      // R4, R11: interleave read burst, start low bits 1, order toggled in burst
      step(1, 1, 0, 16'h3001, 1, "R4");
      for (int i = 0; i < 5; i++) step(1, 0, 1, 16'h0000, i % 2, "R11");
      step(1, 1, 0, 16'h4003, 1, "R4");
      for (int i = 0; i < 4; i++) step(1, 0, 0, 16'h0000, 0, "R4");
      // R8: reload mid-burst with new direction
      step(1, 1, 1, 16'h7772, 0, "R8");
      step(1, 0, 0, 16'h0000, 0, "R8");
      step(1, 1, 0, 16'h1111, 1, "R8");
      step(1, 0, 1, 16'h0000, 0, "R8");
      // random mix
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom_range(0, 9);
         step(r != 0, r < 3, $urandom_range(0, 1), int'($urandom_range(0, 16'hFFFF)),
              $urandom_range(0, 1), "R3");
      end
      @(negedge clk);
      compare();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule